// File: doc/BRIEF.md
# Phase-Coherent Sine Stimulus and Single-Bin Correlator

This block drives a stepped sine onto a DAC sample stream and measures one tone in a returning ADC stream. A 27-bit phase register advances by a programmed step word once every four clocks. The top ten phase bits address a sine table, and that table feeds both the DAC and the correlation references. Every sixteenth clock during acquisition, the block requests one ADC sample and multiplies it by the cosine and sine references for the current phase. It sums 1024 such products into a real and an imaginary result.

The tone frequency is fclk·M/2^29. The acquisition window holds M/2^15 tone periods, so a step word that is a whole multiple of 2^15 leaves no leakage. A start strobe may ask for a number of whole settling periods before acquisition. Two copies that share a clock and a start strobe stay in lock-step. This lets one copy measure the voltage across a load while another copy measures the current through it, both against the same phase reference.

Top module: `tone_probe`

## Requirements
- R1: After an accepted start, the 27-bit phase register begins at zero. It adds the latched step word at the end of every fourth clock, and it holds between updates. After a run, it freezes at its final value until the next start.
- R2: `dac_sample` equals S(k), where k is the top 10 bits of the phase register and S(k) = round(2047·sin(2π(k+0.5)/1024)), with halves rounded away from zero. After reset, the phase is zero and `dac_sample` is 6.
- R3: The cosine reference at table index k is S((k+256) mod 1024).
- R4: Count clocks from c = 0, the first clock after the accepting edge. `sample_req` is high for one clock at cycles c ≡ 15 (mod 16) while acquisition runs, and at no other time.
- R5: A measurement takes exactly 1024 samples. `done` is high in the clock after the clock of the 1024th request.
- R6: `re_out` = Σ x·C and `im_out` = −Σ x·S, exact in 40-bit two's complement. Here x is `adc_sample` in each request clock, and C and S are the cosine and sine references of that clock's phase.
- R7: `done` is a single-clock pulse. `re_out` and `im_out` change only in a clock where `done` is high and are held otherwise; both are zero after reset.
- R8: With a settling count P, the first request falls on the first cycle c ≡ 15 (mod 16) by which the phase register has wrapped P times. With P = 0, it falls at c = 15.
- R9: The step word and settling count are captured when a start is accepted. Later changes to those inputs do not affect the run.
- R10: A start while a run (settling or acquisition) is in progress is ignored, and the run continues with unchanged timing and results.
- R11: Two instances with a common clock, start strobe, step word and settling count produce identical `dac_sample` streams and coherent results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run when idle |
| step_word | input | 27 | Phase increment M |
| settle_periods | input | 8 | Whole tone periods to run before acquisition |
| adc_sample | input | 12 | Signed ADC sample, taken in request clocks |
| dac_sample | output | 12 | Signed stepped sine for the DAC |
| sample_req | output | 1 | Sample request strobe |
| re_out | output | 40 | Signed real correlation result |
| im_out | output | 40 | Signed imaginary correlation result |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench targets the following corner cases, and what a wrong design would show in each:

- **Request phase.** A design that takes the sample one clock early or late, or at a phase update instead of in its own slot, pairs each sample with the wrong reference, so the exact sums differ.
- **Settling count.** Counting table wraps instead of phase-register carries, or counting one period too few, moves the first request and the done pulse. The settling case with P = 2 exposes this.
- **Step word near 2^27.** A step word just below 2^27 wraps on almost every update, which exposes carry handling.
- **Restart mid-run.** A restart issued during acquisition, together with a change of step word, would restart or retune a design that does not latch its inputs.
- **Second instance.** A second instance fed the negated signal must return exactly the negated sums. Any phase skew between the two copies breaks this equality.

// File: rtl/tone_probe_pkg.sv
package tone_probe_pkg;

   typedef enum logic [1:0] {
      TP_IDLE   = 2'd0,
      TP_SETTLE = 2'd1,
      TP_ACQ    = 2'd2
   } tp_state_e;

   localparam real TP_PI = 3.141592653589793;

   // Half-step offset sine sample, rounded half away from zero.
   function automatic int sine_entry(int idx, int size, int amp);
      real a;
      a = real'(amp) * $sin(2.0 * TP_PI * (real'(idx) + 0.5) / real'(size));
      if (a >= 0.0) return $rtoi(a + 0.5);
      else          return $rtoi(a - 0.5);
   endfunction

endpackage

// File: rtl/tone_probe_timing.sv
module tone_probe_timing
   import tone_probe_pkg::*;
#(
   parameter int PHASE_W    = 27,
   parameter int LUT_AW     = 10,
   parameter int PRE_W      = 8,
   parameter int PHASE_DIV  = 4,
   parameter int SAMPLE_DIV = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [PHASE_W-1:0] step_word,
   input  logic [PRE_W-1:0]   settle_periods,
   input  logic               last_sample,
   output logic [LUT_AW-1:0]  lut_addr,
   output logic               sample_req
);

   localparam int DIV_W  = $clog2(SAMPLE_DIV);
   localparam int STEP_W = $clog2(PHASE_DIV);

   tp_state_e          st;
   logic [DIV_W-1:0]   div;
   logic [PHASE_W-1:0] ph;
   logic [PHASE_W-1:0] m_q;
   logic [PRE_W-1:0]   left;
   logic               step;
   logic [PHASE_W:0]   sum;

   assign step       = (st != TP_IDLE) && (div[STEP_W-1:0] == STEP_W'(PHASE_DIV - 1));
   assign sum        = {1'b0, ph} + {1'b0, m_q};
   assign sample_req = (st == TP_ACQ) && (div == DIV_W'(SAMPLE_DIV - 1));
   assign lut_addr   = ph[PHASE_W-1 -: LUT_AW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= TP_IDLE;
         div  <= '0;
         ph   <= '0;
         m_q  <= '0;
         left <= '0;
      end else if (st == TP_IDLE) begin
         if (start) begin
            ph   <= '0;
            div  <= '0;
            m_q  <= step_word;
            left <= settle_periods;
            st   <= (settle_periods == '0) ? TP_ACQ : TP_SETTLE;
         end
      end else begin
         div <= div + 1'b1;
         if (step) ph <= sum[PHASE_W-1:0];
         if (st == TP_SETTLE && step && sum[PHASE_W]) begin
            left <= left - 1'b1;
            if (left == PRE_W'(1)) st <= TP_ACQ;
         end
         if (last_sample) st <= TP_IDLE;
      end
   end

   // R1: phase holds between its periodic updates
   a_r1_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st != TP_IDLE && !step) |=> $stable(ph));

   // R10: a run in progress is never restarted; its clock divider keeps counting
   a_r10_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (st != TP_IDLE) |=> (div == $past(div) + 1'b1));

   // R9: the captured step word stays fixed for the whole run
   a_r9_word_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (st != TP_IDLE) |=> $stable(m_q));

   // R8: settling always leads into acquisition, never back to idle
   a_r8_settle_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TP_SETTLE) |=> (st != TP_IDLE));

endmodule

// File: rtl/tone_probe_wave.sv
module tone_probe_wave #(
   parameter int LUT_AW       = 10,
   parameter int AMP_W        = 12,
   parameter bit QUARTER_WAVE = 1'b1
) (
   input  logic [LUT_AW-1:0]       addr,
   output logic signed [AMP_W-1:0] val
);

   localparam int FULL = 2 ** LUT_AW;
   localparam int QTR  = FULL / 4;
   localparam int AMP  = 2 ** (AMP_W - 1) - 1;

   generate
      if (QUARTER_WAVE) begin : g_quarter
         logic signed [AMP_W-1:0] qtab [QTR];
         logic [LUT_AW-3:0]       idx;
         logic signed [AMP_W-1:0] mag;
         for (genvar i = 0; i < QTR; i++) begin : g_ent
            localparam int V = tone_probe_pkg::sine_entry(i, FULL, AMP);
            assign qtab[i] = AMP_W'(V);
         end
         assign idx = addr[LUT_AW-2] ? ~addr[LUT_AW-3:0] : addr[LUT_AW-3:0];
         assign mag = qtab[idx];
         assign val = addr[LUT_AW-1] ? -mag : mag;
      end else begin : g_full
         logic signed [AMP_W-1:0] ftab [FULL];
         for (genvar i = 0; i < FULL; i++) begin : g_ent
            localparam int V = tone_probe_pkg::sine_entry(i, FULL, AMP);
            assign ftab[i] = AMP_W'(V);
         end
         assign val = ftab[addr];
      end
   endgenerate

endmodule

// File: rtl/tone_probe_corr.sv
module tone_probe_corr #(
   parameter int SAMPLE_W  = 12,
   parameter int AMP_W     = 12,
   parameter int ACC_W     = 40,
   parameter int N_SAMPLES = 1024
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sample_req,
   input  logic signed [SAMPLE_W-1:0] adc_sample,
   input  logic signed [AMP_W-1:0]    sin_ref,
   input  logic signed [AMP_W-1:0]    cos_ref,
   output logic                       last_sample,
   output logic signed [ACC_W-1:0]    re_out,
   output logic signed [ACC_W-1:0]    im_out,
   output logic                       done
);

   localparam int CNT_W  = $clog2(N_SAMPLES);
   localparam int PROD_W = SAMPLE_W + AMP_W;

   logic [CNT_W-1:0]          cnt;
   logic signed [ACC_W-1:0]   acc_re;
   logic signed [ACC_W-1:0]   acc_im;
   logic signed [PROD_W-1:0]  p_re;
   logic signed [PROD_W-1:0]  p_im;
   logic signed [ACC_W-1:0]   nxt_re;
   logic signed [ACC_W-1:0]   nxt_im;

   assign p_re        = adc_sample * cos_ref;
   assign p_im        = adc_sample * sin_ref;
   assign nxt_re      = acc_re + ACC_W'(p_re);
   assign nxt_im      = acc_im - ACC_W'(p_im);
   assign last_sample = sample_req && (cnt == CNT_W'(N_SAMPLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         acc_re <= '0;
         acc_im <= '0;
         re_out <= '0;
         im_out <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (last_sample) begin
            re_out <= nxt_re;
            im_out <= nxt_im;
            acc_re <= '0;
            acc_im <= '0;
            cnt    <= '0;
            done   <= 1'b1;
         end else if (sample_req) begin
            acc_re <= nxt_re;
            acc_im <= nxt_im;
            cnt    <= cnt + 1'b1;
         end
      end
   end

   // R4: requests never come on consecutive clocks
   a_r4_req_gap: assert property (@(posedge clk) disable iff (!rst_n)
      sample_req |=> !sample_req);

   // R5: completion directly follows a sample request
   a_r5_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(sample_req));

   // R7: done lasts one clock, results hold between completions
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r7_hold_re: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(re_out));
   a_r7_hold_im: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(im_out));

endmodule

// File: rtl/tone_probe.sv
module tone_probe #(
   parameter int PHASE_W      = 27,
   parameter int LUT_AW       = 10,
   parameter int AMP_W        = 12,
   parameter int SAMPLE_W     = 12,
   parameter int ACC_W        = 40,
   parameter int N_SAMPLES    = 1024,
   parameter int PHASE_DIV    = 4,
   parameter int SAMPLE_DIV   = 16,
   parameter int PRE_W        = 8,
   parameter bit QUARTER_WAVE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [PHASE_W-1:0]         step_word,
   input  logic [PRE_W-1:0]           settle_periods,
   input  logic signed [SAMPLE_W-1:0] adc_sample,
   output logic signed [AMP_W-1:0]    dac_sample,
   output logic                       sample_req,
   output logic signed [ACC_W-1:0]    re_out,
   output logic signed [ACC_W-1:0]    im_out,
   output logic                       done
);

   localparam int QTR_OFS = 2 ** (LUT_AW - 2);
   localparam int MIN_ACC = SAMPLE_W + AMP_W + $clog2(N_SAMPLES);

   generate
      if (PHASE_W <= LUT_AW || LUT_AW < 3)
         begin : g_bad_lut   $error("tone_probe: LUT_AW must be 3..PHASE_W-1"); end
      if (PHASE_DIV < 2 || (PHASE_DIV & (PHASE_DIV - 1)) != 0)
         begin : g_bad_pdiv  $error("tone_probe: PHASE_DIV must be a power of two >= 2"); end
      if (SAMPLE_DIV < PHASE_DIV || (SAMPLE_DIV & (SAMPLE_DIV - 1)) != 0)
         begin : g_bad_sdiv  $error("tone_probe: SAMPLE_DIV must be a power of two >= PHASE_DIV"); end
      if (N_SAMPLES < 2)
         begin : g_bad_n     $error("tone_probe: N_SAMPLES must be at least 2"); end
      if (ACC_W < MIN_ACC)
         begin : g_bad_acc   $error("tone_probe: ACC_W too narrow for the sum"); end
   endgenerate

   logic [LUT_AW-1:0]       sin_addr;
   logic [LUT_AW-1:0]       cos_addr;
   logic signed [AMP_W-1:0] sin_ref;
   logic signed [AMP_W-1:0] cos_ref;
   logic                    last_sample;

   assign cos_addr   = sin_addr + LUT_AW'(QTR_OFS);
   assign dac_sample = sin_ref;

   tone_probe_timing #(
      .PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .PRE_W(PRE_W),
      .PHASE_DIV(PHASE_DIV), .SAMPLE_DIV(SAMPLE_DIV)
   ) i_timing (
      .clk(clk), .rst_n(rst_n), .start(start), .step_word(step_word),
      .settle_periods(settle_periods), .last_sample(last_sample),
      .lut_addr(sin_addr), .sample_req(sample_req)
   );

   tone_probe_wave #(.LUT_AW(LUT_AW), .AMP_W(AMP_W), .QUARTER_WAVE(QUARTER_WAVE))
      i_sin (.addr(sin_addr), .val(sin_ref));

   tone_probe_wave #(.LUT_AW(LUT_AW), .AMP_W(AMP_W), .QUARTER_WAVE(QUARTER_WAVE))
      i_cos (.addr(cos_addr), .val(cos_ref));

   tone_probe_corr #(
      .SAMPLE_W(SAMPLE_W), .AMP_W(AMP_W), .ACC_W(ACC_W), .N_SAMPLES(N_SAMPLES)
   ) i_corr (
      .clk(clk), .rst_n(rst_n), .sample_req(sample_req), .adc_sample(adc_sample),
      .sin_ref(sin_ref), .cos_ref(cos_ref), .last_sample(last_sample),
      .re_out(re_out), .im_out(im_out), .done(done)
   );

endmodule

// File: tb/test_tone_probe.sv
module test_tone_probe;

   localparam int CLK_PERIOD = 10;
   localparam longint WRAP   = 64'd1 << 27;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [26:0]        step_word = '0;
   logic [7:0]         settle_periods = '0;
   logic               src_loop = 1'b0;
   logic signed [11:0] const_val = '0;

   logic signed [11:0] adc_a, adc_b, dac_a, dac_b;
   logic               req_a, req_b, done_a, done_b;
   logic signed [39:0] re_a, im_a, re_b, im_b;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign adc_a = src_loop ? dac_a : const_val;
   assign adc_b = -adc_a;

   tone_probe i_tone_probe (
      .clk(clk), .rst_n(rst_n), .start(start), .step_word(step_word),
      .settle_periods(settle_periods), .adc_sample(adc_a), .dac_sample(dac_a),
      .sample_req(req_a), .re_out(re_a), .im_out(im_a), .done(done_a)
   );

   tone_probe i_tone_probe_b (
      .clk(clk), .rst_n(rst_n), .start(start), .step_word(step_word),
      .settle_periods(settle_periods), .adc_sample(adc_b), .dac_sample(dac_b),
      .sample_req(req_b), .re_out(re_b), .im_out(im_b), .done(done_b)
   );

   function automatic longint ref_sin(longint k);
      real a;
      a = 2047.0 * $sin(2.0 * 3.141592653589793 * (real'(k) + 0.5) / 1024.0);
      if (a >= 0.0) return longint'($rtoi(a + 0.5));
      else          return longint'($rtoi(a - 0.5));
   endfunction

   function automatic longint idx_at(longint m, longint c);
      return ((m * (c / 4)) % WRAP) >> 17;
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic t_reset;
      chk(dac_a == 12'sd6, "R2", "reset dac", dac_a, 6);
      chk(done_a == 1'b0, "R7", "reset done", done_a, 0);
      chk(re_a == 0 && im_a == 0, "R7", "reset results", re_a, 0);
      chk(req_a == 1'b0, "R4", "reset request", req_a, 0);
   endtask

   task automatic run_case(string tag, longint m, int p, bit loopback,
                           int cval, bit disturb);
      longint cf, cd, e_re, e_im, exp_dac, cc;
      int dac_bad, req_bad, req_n, coh_bad, hold_bad;
      longint done_c;
      e_re = 0; e_im = 0; dac_bad = 0; req_bad = 0; req_n = 0;
      coh_bad = 0; hold_bad = 0; done_c = -1;
      cf = 15;
      while (((m * (cf / 4)) >> 27) < longint'(p)) cf += 16;
      cd = cf + 16 * 1023 + 1;
      for (int j = 0; j < 1024; j++) begin
         longint c, k, x;
         c = cf + 16 * j;
         k = idx_at(m, c);
         x = loopback ? ref_sin(k) : longint'(cval);
         e_re += x * ref_sin((k + 256) % 1024);
         e_im -= x * ref_sin(k);
      end
      src_loop = loopback;
      const_val = 12'(cval);
      step_word = 27'(m);
      settle_periods = 8'(p);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      for (longint c = 0; c <= cd + 20; c++) begin
         bit exp_req;
         cc = (c > cd) ? cd : c;
         exp_dac = ref_sin(idx_at(m, cc));
         if (longint'(dac_a) != exp_dac) dac_bad++;
         if (dac_b != dac_a) coh_bad++;
         exp_req = (c >= cf) && (c < cd) && (((c - cf) % 16) == 0);
         if (req_a != exp_req) req_bad++;
         if (req_a) req_n++;
         if (done_a && done_c < 0) done_c = c;
         if (c == cd) begin
            chk(re_a == 40'(e_re), "R6", {tag, " real result (R3 cosine)"}, re_a, e_re);
            chk(im_a == 40'(e_im), "R6", {tag, " imaginary result"}, im_a, e_im);
            chk(re_b == -re_a && im_b == -im_a, "R11", {tag, " coherent second result"},
                im_b, -im_a);
         end
         if (c > cd && (done_a || re_a != 40'(e_re) || im_a != 40'(e_im) || req_a))
            hold_bad++;
         if (disturb && c == 5000) begin
            start = 1'b1;
            step_word = 27'(m + 777);
            settle_periods = 8'd9;
         end
         if (disturb && c == 5001) start = 1'b0;
         @(negedge clk);
      end
      chk(dac_bad == 0, "R1", {tag, " dac stair sequence (R2)"}, dac_bad, 0);
      chk(req_bad == 0, "R4", {tag, " request positions (R8)"}, req_bad, 0);
      chk(req_n == 1024, "R5", {tag, " request count"}, req_n, 1024);
      chk(done_c == cd, "R5", {tag, " done cycle (R8)"}, done_c, cd);
      chk(coh_bad == 0, "R11", {tag, " dac lock-step"}, coh_bad, 0);
      chk(hold_bad == 0, "R7", {tag, " hold after done"}, hold_bad, 0);
   endtask

   task automatic t_integer_periods;  // R6, R2: four whole periods, loopback
      run_case("int4", 64'd4 << 15, 0, 1'b1, 0, 1'b0);
   endtask

   task automatic t_leaky_const;      // R3, R6: non-integer periods, constant input
      run_case("leaky", 3 * (64'd1 << 15) + 12345, 0, 1'b0, 700, 1'b0);
   endtask

   task automatic t_settling;         // R8: two settling periods
      run_case("settle2", 64'd1 << 22, 2, 1'b1, 0, 1'b0);
   endtask

   task automatic t_restart_ignored;  // R9, R10: restart and new word mid-run
      run_case("restart", 64'd5 << 15, 0, 1'b0, -1234, 1'b1);
   endtask

   task automatic t_max_step;         // R1, R8: step word just below full scale
      run_case("maxstep", WRAP - 1, 1, 1'b1, 0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset;
      t_integer_periods;
      t_leaky_const;
      t_settling;
      t_restart_ignored;
      t_max_step;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(longint'(CLK_PERIOD) * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule